// File: doc/BRIEF.md
# Host Mailbox Parallel Port

This block is the slave end of an 8-bit parallel link that lets an external microcontroller read and write a small bank of mailbox registers inside the chip. Two strap inputs fix the bus convention for the life of the system. One strap chooses between a pair of separate read and write strobes, or a direction level qualified by a single data strobe. The other strap chooses between dedicated address pins, or an address sent over the data lines and marked by an address latch enable.

The host control pins are asynchronous to the internal clock. They pass through a two-stage synchroniser. Each selected strobe then causes exactly one register operation and a handshaking acknowledge. The processor side uses a plain single-cycle read/write port. Two vectors of per-register flags report fresh data in each direction, and each flag clears when the opposite side reads that register. At chip level the data pins are split into input, output and output-enable signals, which a bidirectional pad combines.

Top module: `hostif_port`

## Requirements
- R1: With `strap_strobe` = 0, `host_rd_rw` low is a read and `host_wr_ds_n` low (with `host_rd_rw` high) is a write. Both pins are active low.
- R2: With `strap_strobe` = 1, `host_wr_ds_n` low is the access strobe. `host_rd_rw` gives the direction: 1 is a read and 0 is a write.
- R3: With `strap_muxed` = 0, the three `host_addr` pins select register 0 to 7 for both reads and writes.
- R4: With `strap_muxed` = 1, `host_addr[2]` is the address latch enable. `host_din[2:0]` is captured on the third clock edge after the latch enable falls and is used for the following data phase. `host_addr[1:0]` have no effect.
- R5: While `host_sel_n` is high, strobes cause no acknowledge, no register change, no flag change and no output enable.
- R6: `host_ack` (active high) rises on the third clock edge after select and strobe are both active. It stays high while they remain active. It falls on the third clock edge after either one goes inactive.
- R7: `host_doe` is high exactly while select is low and a read strobe is decoded (combinationally from the pins). During a read, `host_dout` shows the addressed register.
- R8: A host write stores `host_din` and sets `host_new[addr]`. A `cpu_rd_en` cycle at that address clears the bit. If both happen on the same edge, the set wins.
- R9: A `cpu_wr_en` cycle stores `cpu_wdata` and sets `cpu_new[addr]`. A host read of that register clears the bit.
- R10: After reset, all registers read 0, both flag vectors are 0 and `host_ack` is 0.
- R11: A strobe held active performs its operation once. A flag cleared during a long strobe is not set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_strobe | input | 1 | 0: separate read/write strobes; 1: direction level plus data strobe |
| strap_muxed | input | 1 | 0: separate address pins; 1: address multiplexed on data |
| host_sel_n | input | 1 | Host chip select, active low |
| host_rd_rw | input | 1 | Read strobe (active low) or direction level (1 = read) |
| host_wr_ds_n | input | 1 | Write strobe or data strobe, active low |
| host_addr | input | 3 | Register address; bit 2 is the latch enable in multiplexed mode |
| host_din | input | 8 | Data (and address) from the host pad |
| host_dout | output | 8 | Read data to the host pad |
| host_doe | output | 1 | Pad output enable |
| host_ack | output | 1 | Access acknowledge, active high |
| cpu_wr_en | input | 1 | Processor-side write enable |
| cpu_rd_en | input | 1 | Processor-side read (clears host flag) |
| cpu_addr | input | 3 | Processor-side register index |
| cpu_wdata | input | 8 | Processor-side write data |
| cpu_rdata | output | 8 | Processor-side read data, combinational |
| host_new | output | 8 | Per-register flag: host wrote, processor not yet read |
| cpu_new | output | 8 | Per-register flag: processor wrote, host not yet read |

## Verification
The bound checker watches these on every cycle:
- An acknowledge rises only when select was low two edges earlier.
- A `host_new` bit rises only together with a new acknowledge, and falls only after a processor read.
- A `cpu_new` bit rises only after a processor write, and falls only with a new acknowledge.

Some behaviour is shown only by the bench scenarios. These are the exact acknowledge latency, the read data and the output enable in every strap combination, the address latching, the ignored low address pins and the held-strobe case. The bench sweeps all four strap combinations over all eight registers in both directions.

// File: rtl/hostif_pkg.sv
// Shared types for the host mailbox port.
package hostif_pkg;

    // Access state of the host-side handshake.
    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_HOLD = 1'b1
    } acc_state_e;

    // Asynchronous host control pins, grouped for synchronisation.
    typedef struct packed {
        logic sel_n;
        logic rd_rw;
        logic wr_ds_n;
        logic ale;
    } host_pins_t;

    // Idle level of each pin: select and strobes high, latch enable low.
    localparam host_pins_t PINS_IDLE = '{sel_n: 1'b1, rd_rw: 1'b1, wr_ds_n: 1'b1, ale: 1'b0};

endpackage

// File: rtl/hostif_sync.sv
// Multi-stage synchroniser for a group of asynchronous inputs.
// Assumes each bit is independent; multi-bit coherence is not needed
// because every bit is a level that is held across many clocks.
module hostif_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                // Later flops resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hostif_front.sv
// Host bus front end: decodes both strobe conventions and both
// addressing modes, latches a multiplexed address, runs the
// one-operation-per-strobe handshake and drives the acknowledge.
// Assumes address and data pins are stable while the strobe is
// active, and the multiplexed address is held for at least three
// clocks after the latch enable falls.
module hostif_front
    import hostif_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_strobe,
    input  logic              strap_muxed,
    input  host_pins_t        pins_s,
    input  logic              raw_sel_n,
    input  logic              raw_rd_rw,
    input  logic              raw_wr_ds_n,
    input  logic [ADDR_W-1:0] addr_pins,
    input  logic [ADDR_W-1:0] din_lo,
    output logic              ack,
    output logic              op_fire,
    output logic              op_read,
    output logic [ADDR_W-1:0] op_addr,
    output logic              doe
);
    acc_state_e        state_q;
    logic              ale_q;
    logic [ADDR_W-1:0] addr_lat_q;
    logic              strobe_s;
    logic              acc_s;

    // Decode synchronised strobe and direction for the selected convention.
    always_comb begin
        if (strap_strobe) begin
            strobe_s = !pins_s.wr_ds_n;
            op_read  = pins_s.rd_rw;
        end else begin
            strobe_s = !pins_s.rd_rw || !pins_s.wr_ds_n;
            op_read  = !pins_s.rd_rw;
        end
        acc_s = !pins_s.sel_n && strobe_s;
    end

    // Capture the multiplexed address when the synchronised latch enable falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q      <= 1'b0;
            addr_lat_q <= '0;
        end else begin
            ale_q <= pins_s.ale;
            if (strap_muxed && ale_q && !pins_s.ale) addr_lat_q <= din_lo;
        end
    end

    // Select the effective register address for the current mode.
    assign op_addr = strap_muxed ? addr_lat_q : addr_pins;

    // Handshake: fire once on entry, hold the acknowledge until release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            case (state_q)
                ACC_IDLE: if (acc_s)  state_q <= ACC_HOLD;
                ACC_HOLD: if (!acc_s) state_q <= ACC_IDLE;
                default:              state_q <= ACC_IDLE;
            endcase
        end
    end

    assign op_fire = (state_q == ACC_IDLE) && acc_s;
    assign ack     = (state_q == ACC_HOLD);

    // Pad enable straight from the pins so read data appears without delay.
    assign doe = !raw_sel_n && (strap_strobe ? (!raw_wr_ds_n && raw_rd_rw) : !raw_rd_rw);

endmodule

// File: rtl/hostif_regbank.sv
// Mailbox register bank with per-register new-data flags in both
// directions. A host write to a register overrides a processor
// write to the same register on the same edge; a flag set beats a
// clear on the same edge.
module hostif_regbank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              c_wr,
    input  logic              c_rd,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_wdata,
    output logic [DATA_W-1:0] c_rdata,
    output logic [NREG-1:0]   host_new,
    output logic [NREG-1:0]   cpu_new
);
    logic [DATA_W-1:0] mem_q [NREG];
    logic [NREG-1:0]   h_new_q;
    logic [NREG-1:0]   c_new_q;

    // Register storage: host write first, then processor write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)                                   mem_q[i] <= '0;
            else if (h_wr && h_addr == ADDR_W'(i))        mem_q[i] <= h_wdata;
            else if (c_wr && c_addr == ADDR_W'(i))        mem_q[i] <= c_wdata;
        end
    end

    // New-data flags: set by the writer, cleared by the opposite reader.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) begin
                h_new_q[i] <= 1'b0;
                c_new_q[i] <= 1'b0;
            end else begin
                if (h_wr && h_addr == ADDR_W'(i))      h_new_q[i] <= 1'b1;
                else if (c_rd && c_addr == ADDR_W'(i)) h_new_q[i] <= 1'b0;
                if (c_wr && c_addr == ADDR_W'(i))      c_new_q[i] <= 1'b1;
                else if (h_rd && h_addr == ADDR_W'(i)) c_new_q[i] <= 1'b0;
            end
        end
    end

    assign h_rdata  = mem_q[h_addr];
    assign c_rdata  = mem_q[c_addr];
    assign host_new = h_new_q;
    assign cpu_new  = c_new_q;
endmodule

// File: rtl/hostif_port.sv
// Host mailbox parallel port, top level. Synchronises the host
// control pins, decodes the strapped bus convention and connects
// the resulting single-shot operations to the mailbox bank.
// Assumes straps change only while reset is held.
module hostif_port
    import hostif_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    localparam int NREG       = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_strobe,
    input  logic              strap_muxed,
    input  logic              host_sel_n,
    input  logic              host_rd_rw,
    input  logic              host_wr_ds_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    output logic              host_ack,
    input  logic              cpu_wr_en,
    input  logic              cpu_rd_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [NREG-1:0]   host_new,
    output logic [NREG-1:0]   cpu_new
);
    host_pins_t        pins_raw;
    host_pins_t        pins_s;
    logic              op_fire;
    logic              op_read;
    logic [ADDR_W-1:0] op_addr;

    // Group the asynchronous pins; the top address bit doubles as latch enable.
    always_comb begin
        pins_raw.sel_n   = host_sel_n;
        pins_raw.rd_rw   = host_rd_rw;
        pins_raw.wr_ds_n = host_wr_ds_n;
        pins_raw.ale     = strap_muxed && host_addr[ADDR_W-1];
    end

    hostif_sync #(
        .W       ($bits(host_pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    hostif_front #(
        .ADDR_W (ADDR_W)
    ) u_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_strobe (strap_strobe),
        .strap_muxed  (strap_muxed),
        .pins_s       (pins_s),
        .raw_sel_n    (host_sel_n),
        .raw_rd_rw    (host_rd_rw),
        .raw_wr_ds_n  (host_wr_ds_n),
        .addr_pins    (host_addr),
        .din_lo       (host_din[ADDR_W-1:0]),
        .ack          (host_ack),
        .op_fire      (op_fire),
        .op_read      (op_read),
        .op_addr      (op_addr),
        .doe          (host_doe)
    );

    hostif_regbank #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_wr     (op_fire && !op_read),
        .h_rd     (op_fire && op_read),
        .h_addr   (op_addr),
        .h_wdata  (host_din),
        .h_rdata  (host_dout),
        .c_wr     (cpu_wr_en),
        .c_rd     (cpu_rd_en),
        .c_addr   (cpu_addr),
        .c_wdata  (cpu_wdata),
        .c_rdata  (cpu_rdata),
        .host_new (host_new),
        .cpu_new  (cpu_new)
    );
endmodule

// File: rtl/hostif_port_chk.sv
// Protocol checker for the host mailbox port, bound to the top level.
// Assumes the default two-stage synchroniser.
module hostif_port_chk #(
    parameter int NREG = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_sel_n,
    input logic            host_ack,
    input logic            cpu_wr_en,
    input logic            cpu_rd_en,
    input logic [NREG-1:0] host_new,
    input logic [NREG-1:0] cpu_new
);
    // R5 R6
    ack_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack) |-> $past(!host_sel_n, 2));

    // R8
    host_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(host_new & ~$past(host_new))) |-> $rose(host_ack));

    // R8
    host_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(host_new) & ~host_new)) |-> $past(cpu_rd_en));

    // R9
    cpu_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cpu_new & ~$past(cpu_new))) |-> $past(cpu_wr_en));

    // R9
    cpu_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(cpu_new) & ~cpu_new)) |-> $rose(host_ack));
endmodule

bind hostif_port hostif_port_chk #(.NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel_n (host_sel_n),
    .host_ack   (host_ack),
    .cpu_wr_en  (cpu_wr_en),
    .cpu_rd_en  (cpu_rd_en),
    .host_new   (host_new),
    .cpu_new    (cpu_new)
);

// File: tb/hostif_port_bench.sv
module hostif_port_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_strobe = 1'b0, strap_muxed = 1'b0;
    logic       host_sel_n = 1'b1, host_rd_rw = 1'b1, host_wr_ds_n = 1'b1;
    logic [2:0] host_addr = '0;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic       host_doe, host_ack;
    logic       cpu_wr_en = 1'b0, cpu_rd_en = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [7:0] host_new, cpu_new;

    int checks = 0;
    int failures = 0;

    hostif_port u_hostif_port (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Strobe drive in the strapped convention (R1/R2).
    task automatic strobe(input bit on, input bit rd);
        if (!strap_strobe) begin
            host_rd_rw   = !(on && rd);
            host_wr_ds_n = !(on && !rd);
        end else begin
            host_wr_ds_n = !on;
        end
    endtask

    // One full host access with latency, enable and data checks.
    task automatic host_access(input bit rd, input logic [2:0] a, input logic [7:0] wv,
                               input logic [7:0] exp, input logic [1:0] junk);
        if (strap_muxed) begin
            host_addr = {1'b1, junk};
            host_din  = {5'b10110, a};
            repeat (3) @(negedge clk);
            host_addr = {1'b0, junk};
            repeat (4) @(negedge clk);
            host_din = rd ? 8'h00 : wv;
        end else begin
            host_addr = a;
            host_din  = wv;
        end
        @(negedge clk);
        host_sel_n = 1'b0;
        if (strap_strobe) host_rd_rw = rd;
        @(negedge clk);
        strobe(1'b1, rd);
        #1 chk(host_doe == rd, "R7 doe during access", host_doe, rd);
        @(negedge clk);
        @(negedge clk);
        chk(host_ack == 1'b0, "R6 ack not before third edge", host_ack, 0);
        @(negedge clk);
        chk(host_ack == 1'b1, "R6 ack on third edge", host_ack, 1);
        if (rd) chk(host_dout == exp, strap_strobe ? "R2 R3 R4 R7 read data" : "R1 R3 R4 R7 read data", host_dout, exp);
        strobe(1'b0, rd);
        host_sel_n = 1'b1;
        host_rd_rw = 1'b1;
        #1 chk(host_doe == 1'b0, "R7 doe released", host_doe, 0);
        @(negedge clk);
        @(negedge clk);
        chk(host_ack == 1'b1, "R6 ack held through sync", host_ack, 1);
        @(negedge clk);
        chk(host_ack == 1'b0, "R6 ack released", host_ack, 0);
        host_addr = '0;
    endtask

    task automatic cpu_read(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        cpu_addr  = a;
        cpu_rd_en = 1'b1;
        #1 chk(cpu_rdata == exp, req, cpu_rdata, exp);
        @(negedge clk);
        cpu_rd_en = 1'b0;
        chk(host_new[a] == 1'b0, "R8 host flag cleared by cpu read", host_new[a], 0);
    endtask

    task automatic cpu_write(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = v;
        cpu_wr_en = 1'b1;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        chk(cpu_new[a] == 1'b1, "R9 cpu flag set", cpu_new[a], 1);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            strap_strobe = c[0];
            strap_muxed  = c[1];
            do_reset();
            chk(host_ack == 1'b0, "R10 ack after reset", host_ack, 0);
            chk(host_new == 8'h00, "R10 host flags after reset", host_new, 0);
            chk(cpu_new == 8'h00, "R10 cpu flags after reset", cpu_new, 0);
            for (int a = 0; a < 8; a++) begin
                cpu_addr = 3'(a);
                #1 chk(cpu_rdata == 8'h00, "R10 register after reset", cpu_rdata, 0);
            end
            for (int a = 0; a < 8; a++) begin
                logic [7:0] wv = 8'(8'hA5 ^ (a * 37) ^ (c << 6));
                logic [7:0] cv = 8'(8'h3C + a * 29 + c * 3);
                host_access(1'b0, 3'(a), wv, 8'h00, 2'(~a));
                chk(host_new == 8'(1 << a), "R3 R4 R8 host write sets one flag", host_new, 8'(1 << a));
                cpu_read(3'(a), wv, "R3 R4 R8 host write data at processor");
                cpu_write(3'(a), cv);
                host_access(1'b1, 3'(a), 8'h00, cv, 2'(a + 1));
                chk(cpu_new[a] == 1'b0, "R9 cpu flag cleared by host read", cpu_new[a], 0);
            end
        end

        // Select gating (R5) and held strobe (R11) in separate/separate mode.
        strap_strobe = 1'b0;
        strap_muxed  = 1'b0;
        do_reset();
        cpu_write(3'd2, 8'h77);
        host_addr = 3'd2;
        host_din  = 8'hEE;
        @(negedge clk);
        strobe(1'b1, 1'b0);
        repeat (6) @(negedge clk);
        chk(host_ack == 1'b0, "R5 no ack without select", host_ack, 0);
        chk(host_new == 8'h00, "R5 no flag without select", host_new, 0);
        cpu_addr = 3'd2;
        #1 chk(cpu_rdata == 8'h77, "R5 register untouched without select", cpu_rdata, 8'h77);
        strobe(1'b0, 1'b0);
        strobe(1'b1, 1'b1);
        #1 chk(host_doe == 1'b0, "R5 no enable without select", host_doe, 0);
        repeat (6) @(negedge clk);
        chk(cpu_new[2] == 1'b1, "R5 cpu flag kept without select", cpu_new[2], 1);
        strobe(1'b0, 1'b1);
        @(negedge clk);

        host_addr  = 3'd5;
        host_din   = 8'h5A;
        host_sel_n = 1'b0;
        strobe(1'b1, 1'b0);
        repeat (4) @(negedge clk);
        chk(host_ack == 1'b1, "R11 ack during held write", host_ack, 1);
        cpu_read(3'd5, 8'h5A, "R11 held write data");
        repeat (5) @(negedge clk);
        chk(host_new[5] == 1'b0, "R11 no second write while held", host_new[5], 0);
        chk(host_ack == 1'b1, "R11 ack still held", host_ack, 1);
        strobe(1'b0, 1'b0);
        host_sel_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(host_ack == 1'b0, "R6 ack released after held write", host_ack, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule